// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves serial words through a single 16-bit register. The host writes four parameters while the port is idle: the word, a bit count, a half-period divisor and a control word. It then pulses `start`. The port makes a serial clock from the system clock and presents output bits on `sdo`. It samples `sdi` and shifts the sampled bits into the register it is emptying. No realignment is done. When fewer than 16 bits move, the bits sent come from one end of the register and the bits received pile up at the other end.

The bit count is a full 16-bit quantity. Counts above 16 let the host keep only the final 16 bits of a longer incoming stream. With both data directions switched off, the port emits a burst of up to 65535 bare clock pulses. A count of zero finishes at once without clocking.

Words move one at a time through the register rather than as a stream. There is therefore no valid/ready pair. The host applies back-pressure by not pulsing `start` again until `done` is high. Control and status pins are plain levels.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, all four host registers read 0, `busy`, `done`, `sclk` and `sdo` are 0.
- R2: Host registers are written at `wr_addr` 0 (word), 1 (bit count), 2 (half-period) and 3 (control) and read back at the same `rd_addr`. Writes of any kind are ignored while `busy` is 1.
- R3: `start` is accepted only while idle; a `start` during a transfer has no effect on its length or result.
- R4: `sclk` changes level every H system clocks, where H is the half-period value (0 acts as 1). The first active edge follows H cycles after the clock edge that accepts `start`, so a transfer of N bits keeps `busy` high for exactly 2·H·N cycles.
- R5: With control bit 2 = 0 (MSB first), `sdo` shows word bit 15 and received bits enter at bit 0. After N<16 bits, the upper N bits have been sent and the received bits occupy the low N bits, with the last one at bit 0.
- R6: With control bit 2 = 1 (LSB first), `sdo` shows word bit 0 and received bits enter at bit 15. After 8 bits, the received byte sits in bits 15:8 and the old upper byte sits in bits 7:0.
- R7: `sdi` is sampled on the edge that leaves the idle level. `sdo` changes only on the edge that returns to idle. For a 16-bit transfer, the whole register is both source and destination.
- R8: Control bit 0 enables driving `sdo` (otherwise `sdo` stays 0) and control bit 1 enables sampling `sdi` (otherwise zeros are shifted in). The value 0 in both bits is clock-only mode.
- R9: In clock-only mode the port emits exactly N pulses and leaves the word register unchanged.
- R10: A bit count above 16 is legal; the register then holds the last 16 bits received.
- R11: A bit count of 0 sets `done` on the clock after `start` and generates no `sclk` activity.
- R12: Control bit 3 sets the idle level of `sclk`, which returns there after the last bit. `done` clears when a transfer is accepted, sets when the count reaches zero, and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register select |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 2 | Host read register select |
| rd_data | output | 16 | Host read data (combinational) |
| start | input | 1 | Transfer start strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume that the half-period, control word and count do not change while `busy` is high. The register block enforces this, and the bench also writes parameters only between transfers, except in one scenario that deliberately tries to write mid-transfer. They also assume `sdi` is settled at each sampling edge. The bench changes `sdi` only on the falling system-clock edge after each leading serial edge, so input never moves on the cycle it is sampled.

// File: rtl/sssp_pkg.sv
package sssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OUT  = 2'd1,
    ST_IN   = 2'd2
  } phase_e;

  localparam logic [1:0] A_WORD = 2'd0;
  localparam logic [1:0] A_LEN  = 2'd1;
  localparam logic [1:0] A_HALF = 2'd2;
  localparam logic [1:0] A_CTL  = 2'd3;

  localparam int C_OUT_EN = 0;
  localparam int C_IN_EN  = 1;
  localparam int C_LSB    = 2;
  localparam int C_IDLE   = 3;
endpackage

// File: rtl/sssp_regs.sv
module sssp_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              busy,
  input  logic [DATA_W-1:0] word_q,
  output logic              word_wr,
  output logic [DATA_W-1:0] len_q,
  output logic [DATA_W-1:0] half_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] rd_data
);
  import sssp_pkg::*;

  logic host_ok;
  assign host_ok = wr_en && !busy;
  assign word_wr = host_ok && (wr_addr == A_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      half_q <= '0;
      ctl_q  <= '0;
    end else if (host_ok) begin
      case (wr_addr)
        A_LEN:   len_q  <= wr_data;
        A_HALF:  half_q <= wr_data;
        A_CTL:   ctl_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_WORD:  rd_data = word_q;
      A_LEN:   rd_data = len_q;
      A_HALF:  rd_data = half_q;
      default: rd_data = ctl_q;
    endcase
  end

  a_r2_params_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(len_q) && $stable(half_q) && $stable(ctl_q)));
endmodule

// File: rtl/sssp_timer.sv
module sssp_timer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] half,
  output logic              tick
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] last;

  assign last = (half == '0) ? '0 : half - ONE;
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + ONE;
  end

  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> !tick);
endmodule

// File: rtl/sssp_ctrl.sv
module sssp_ctrl #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] len,
  input  logic              tick,
  input  logic              idle_lvl,
  output logic              busy,
  output logic              done,
  output logic              lead_en,
  output logic              trail_en,
  output logic              sclk
);
  import sssp_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  phase_e            state_q;
  logic [DATA_W-1:0] bits_q;

  assign busy     = (state_q != ST_IDLE);
  assign lead_en  = (state_q == ST_OUT) && tick;
  assign trail_en = (state_q == ST_IN) && tick;
  assign sclk     = idle_lvl ^ (state_q == ST_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      done    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (len == '0) begin
              done <= 1'b1;
            end else begin
              done    <= 1'b0;
              bits_q  <= len;
              state_q <= ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (tick) state_q <= ST_IN;
        end
        ST_IN: begin
          if (tick) begin
            if (bits_q == ONE) begin
              bits_q  <= '0;
              done    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              bits_q  <= bits_q - ONE;
              state_q <= ST_OUT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_q != '0));
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !trail_en) |=> busy);
  a_r12_sclk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sclk));
endmodule

// File: rtl/sssp_core.sv
module sssp_core #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              lead_en,
  input  logic              trail_en,
  input  logic              out_en,
  input  logic              in_en,
  input  logic              lsb_first,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] word_q
);
  logic sample_q;
  logic moves;

  assign moves = out_en || in_en;
  assign sdo   = (busy && out_en) ? (lsb_first ? word_q[0] : word_q[DATA_W-1]) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sample_q <= 1'b0;
    else if (lead_en) sample_q <= in_en ? sdi : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (host_wr) begin
      word_q <= host_wdata;
    end else if (trail_en && moves) begin
      if (lsb_first) word_q <= {sample_q, word_q[DATA_W-1:1]};
      else           word_q <= {word_q[DATA_W-2:0], sample_q};
    end
  end

  a_r9_clock_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_en && !out_en) |=> $stable(word_q));
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_en && out_en && !in_en && !lsb_first) |=> (word_q[0] == 1'b0));
  a_r7_sdo_on_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(trail_en) && !$past(host_wr)) |-> $stable(sdo));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi
);
  import sssp_pkg::*;

  logic [DATA_W-1:0] word_q, len_q, half_q, ctl_q;
  logic              word_wr, tick, lead_en, trail_en;

  sssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy(busy), .word_q(word_q), .word_wr(word_wr),
    .len_q(len_q), .half_q(half_q), .ctl_q(ctl_q), .rd_data(rd_data)
  );

  sssp_timer #(.DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_q), .tick(tick)
  );

  sssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len_q), .tick(tick),
    .idle_lvl(ctl_q[C_IDLE]), .busy(busy), .done(done), .lead_en(lead_en),
    .trail_en(trail_en), .sclk(sclk)
  );

  sssp_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .host_wr(word_wr), .host_wdata(wr_data), .busy(busy),
    .lead_en(lead_en), .trail_en(trail_en), .out_en(ctl_q[C_OUT_EN]),
    .in_en(ctl_q[C_IN_EN]), .lsb_first(ctl_q[C_LSB]), .sdi(sdi), .sdo(sdo),
    .word_q(word_q)
  );

  a_r8_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[C_OUT_EN] |-> !sdo);
endmodule

// File: tb/sync_shift_port_tb.sv
`timescale 1ns/1ps
module sync_shift_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        start = 1'b0;
  logic        busy, done, sclk, sdo;
  logic        sdi = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] in_stream, out_bits;
  int          lead_cnt, busy_cyc, first_lead;
  logic        sdo_seen, prev_sclk, idle_tb;

  always #2.5 clk = ~clk;

  sync_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .busy(busy), .done(done),
    .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic stream_msb(input logic [63:0] w, input int n);
    in_stream = '0;
    for (int i = 0; i < n; i++) in_stream[i] = w[n-1-i];
  endtask

  function automatic logic [15:0] pack_msb(input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = out_bits[i];
    return r;
  endfunction

  function automatic logic [15:0] pack_lsb(input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = out_bits[i];
    return r;
  endfunction

  task automatic mon_step();
    if (busy) busy_cyc++;
    if (sdo) sdo_seen = 1'b1;
    if (sclk != prev_sclk && sclk != idle_tb) begin
      if (lead_cnt < 64) out_bits[lead_cnt] = sdo;
      lead_cnt++;
      if (lead_cnt == 1) first_lead = busy_cyc;
      sdi = in_stream[lead_cnt & 63];
    end
    prev_sclk = sclk;
  endtask

  task automatic run_xfer(input logic [15:0] len, input logic [15:0] half,
                          input logic [15:0] ctl, input logic [15:0] dat, input bit disturb);
    int guard;
    wr(2'd1, len); wr(2'd2, half); wr(2'd3, ctl); wr(2'd0, dat);
    idle_tb = ctl[3]; lead_cnt = 0; busy_cyc = 0; first_lead = 0;
    sdo_seen = 1'b0; out_bits = '0; sdi = in_stream[0];
    @(negedge clk); prev_sclk = sclk; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) check(done == 1'b0 && busy == 1'b1, "R12 done clears on accept", done, 0);
    guard = 0;
    while (busy && guard < 150000) begin
      mon_step();
      if (disturb && guard == 5) begin start = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd3; end
      if (disturb && guard == 6) begin start = 1'b0; wr_addr = 2'd0; wr_data = 16'hFFFF; end
      if (disturb && guard == 7) wr_en = 1'b0;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(sclk == 0 && sdo == 0, "R1 sclk/sdo", {sclk, sdo}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 16'h0, "R1 register reset", v, 0);
    end
  endtask

  task automatic t_full16();
    logic [15:0] v;
    stream_msb(64'hBEEF, 16);
    run_xfer(16'd16, 16'd2, 16'h0003, 16'h1234, 1'b0);
    rd(2'd0, v);
    check(v == 16'hBEEF, "R7 16-bit receive fills word", v, 16'hBEEF);
    check(pack_msb(16) == 16'h1234, "R7 16-bit send", pack_msb(16), 16'h1234);
    check(busy_cyc == 64, "R4 busy length 2HN", busy_cyc, 64);
    check(done == 1 && sclk == 0, "R12 done and idle", {done, sclk}, 2'b10);
    rd(2'd3, v);
    check(v == 16'h0003, "R2 control readback", v, 16'h0003);
  endtask

  task automatic t_msb8();
    logic [15:0] v;
    stream_msb(64'h5A, 8);
    run_xfer(16'd8, 16'd1, 16'h0003, 16'hA5C3, 1'b0);
    rd(2'd0, v);
    check(v == 16'hC35A, "R5 msb byte lands low", v, 16'hC35A);
    check(pack_msb(8) == 16'h00A5, "R5 msb byte sent from top", pack_msb(8), 16'h00A5);
    check(lead_cnt == 8, "R5 pulse count", lead_cnt, 8);
  endtask

  task automatic t_lsb8();
    logic [15:0] v;
    in_stream = 64'h5A;
    run_xfer(16'd8, 16'd1, 16'h0007, 16'hA5C3, 1'b0);
    rd(2'd0, v);
    check(v == 16'h5AA5, "R6 lsb byte lands high", v, 16'h5AA5);
    check(pack_lsb(8) == 16'h00C3, "R6 lsb byte sent from bottom", pack_lsb(8), 16'h00C3);
  endtask

  task automatic t_timing();
    in_stream = '0;
    run_xfer(16'd2, 16'd3, 16'h0003, 16'h8001, 1'b0);
    check(busy_cyc == 12, "R4 half period 3 busy", busy_cyc, 12);
    check(first_lead == 4, "R4 first edge after H", first_lead, 4);
  endtask

  task automatic t_idle_high();
    logic [15:0] v;
    in_stream = '0;
    run_xfer(16'd4, 16'd2, 16'h000B, 16'hF00F, 1'b0);
    rd(2'd0, v);
    check(v == 16'h00F0, "R12 idle-high transfer result", v, 16'h00F0);
    check(sclk == 1'b1 && lead_cnt == 4, "R12 sclk returns high", {sclk, 8'(lead_cnt)}, 9'h104);
    check(pack_msb(4) == 16'h000F, "R7 sent nibble", pack_msb(4), 16'h000F);
  endtask

  task automatic t_clock_only();
    logic [15:0] v;
    in_stream = '1;
    run_xfer(16'd300, 16'd1, 16'h0000, 16'h9357, 1'b0);
    rd(2'd0, v);
    check(lead_cnt == 300, "R9 clock-only pulse count", lead_cnt, 300);
    check(v == 16'h9357, "R9 word unchanged", v, 16'h9357);
    check(sdo_seen == 1'b0, "R8 sdo quiet clock-only", sdo_seen, 0);
  endtask

  task automatic t_overlong();
    logic [15:0] v;
    stream_msb(64'hABCDE, 20);
    run_xfer(16'd20, 16'd1, 16'h0002, 16'hFFFF, 1'b0);
    rd(2'd0, v);
    check(v == 16'hBCDE, "R10 keeps last 16 bits", v, 16'hBCDE);
    check(sdo_seen == 1'b0, "R8 input-only sdo quiet", sdo_seen, 0);
  endtask

  task automatic t_out_only();
    logic [15:0] v;
    in_stream = '1;
    run_xfer(16'd8, 16'd1, 16'h0001, 16'hA5C3, 1'b0);
    rd(2'd0, v);
    check(v == 16'hC300, "R8 output-only zero fill", v, 16'hC300);
    check(pack_msb(8) == 16'h00A5, "R8 output-only sends", pack_msb(8), 16'h00A5);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    stream_msb(64'h5A, 8);
    run_xfer(16'd8, 16'd2, 16'h0003, 16'hA5C3, 1'b1);
    rd(2'd0, v);
    check(v == 16'hC35A, "R2 word write ignored while busy", v, 16'hC35A);
    check(lead_cnt == 8 && busy_cyc == 32, "R3 restart ignored", lead_cnt, 8);
    rd(2'd1, v);
    check(v == 16'd8, "R2 count write ignored while busy", v, 8);
  endtask

  task automatic t_zero_len();
    logic [15:0] v;
    do_reset();
    wr(2'd0, 16'h7E81);
    @(negedge clk); prev_sclk = sclk; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R11 zero count done next cycle", {done, busy}, 2'b10);
    repeat (5) begin
      @(negedge clk);
      check(sclk == prev_sclk && busy == 1'b0, "R11 no clocks", sclk, prev_sclk);
    end
    rd(2'd0, v);
    check(v == 16'h7E81, "R11 word untouched", v, 16'h7E81);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    in_stream = '0; out_bits = '0; idle_tb = 1'b0; prev_sclk = 1'b0;
    lead_cnt = 0; busy_cyc = 0; first_lead = 0; sdo_seen = 1'b0;
    do_reset();
    t_reset();
    t_full16();
    t_msb8();
    t_lsb8();
    t_timing();
    t_idle_high();
    t_clock_only();
    t_overlong();
    t_out_only();
    t_busy_ignore();
    t_zero_len();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule